// File: doc/BRIEF.md
# Power-Domain Bring-Up Sequencer

This block is a hardware state machine that takes over the software routine which powers up a processor's power domain. A single-cycle start pulse launches the sequence. The block first holds the core in reset and stops it, then enables the crystal clock branch. It polls a clock-off status input until the clock reports running. Next it turns on the block head switch, waits for it to settle, and bypasses the regulator. It then releases the memory clamps and powers the memory banks one at a time. Last, it removes the remaining clamps and lets the core run.

Every settle delay is one microsecond, counted as a parameter number of clock cycles. The clock-ready poll has a bounded number of attempts. If the clock never reports running, the sequencer raises a timeout error and leaves every control output at its last value. A later start pulse restarts the sequence. Successful completion is reported by a one-cycle done pulse. The power switches, the clock generator and the firmware are external to the block.

Top module: `pd_powerup_seq`

## Requirements
- R1: Out of reset, every enable output (core_stop, core_ares, bus_ares_en, xo_clk_en, head_sw_on, ldo_bypass, l2_stby_n, slp_ret_n, all bank_pwr bits, core_clk_en) is 0. The three clamps (qmc_clamp, wl_clamp, io_clamp) are 1, and done and timeout_err are 0.
- R2: A start pulse sampled while idle sets core_stop, core_ares and bus_ares_en on the same clock edge. It also clears timeout_err.
- R3: On the edge after R2, xo_clk_en is set. After that, clk_off is sampled once every TICKS_PER_US cycles. The first sample that finds it low sets head_sw_on on that same edge.
- R4: If clk_off is still high at the POLL_LIMIT-th sample, timeout_err is set on that edge and head_sw_on stays 0. Every control output then keeps its value and no done pulse is produced. The POLL_LIMIT-th sample itself still counts as a success if clk_off is low.
- R5: ldo_bypass is set exactly TICKS_PER_US cycles after head_sw_on.
- R6: qmc_clamp is cleared one cycle after ldo_bypass is set. l2_stby_n and slp_ret_n are both set one cycle after that.
- R7: One cycle after R6, bank_pwr[NUM_BANKS-1] is set. The banks then turn on one per TICKS_PER_US cycles in descending index order down to bank_pwr[0]. At most one bank bit rises per cycle, and no bank bit falls.
- R8: wl_clamp is cleared TICKS_PER_US cycles after bank_pwr[0] is set. io_clamp is cleared on the following cycle.
- R9: On three consecutive cycles after R8, core_ares is cleared, then core_clk_en is set, then core_stop is cleared. done is high for exactly one cycle, on the cycle core_stop clears.
- R10: A start pulse that arrives while a sequence is running has no effect. The running sequence keeps its timing and produces exactly one done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse |
| clk_off | input | 1 | Crystal clock branch reports off while high |
| core_stop | output | 1 | Holds core execution stopped |
| core_ares | output | 1 | Core asynchronous reset |
| bus_ares_en | output | 1 | Bus asynchronous reset enable |
| xo_clk_en | output | 1 | Crystal clock branch enable |
| head_sw_on | output | 1 | Block head switch enable |
| ldo_bypass | output | 1 | Regulator bypass |
| qmc_clamp | output | 1 | Compiler-memory clamp |
| l2_stby_n | output | 1 | L2 data standby, active low |
| slp_ret_n | output | 1 | Memory sleep retention, active low |
| bank_pwr | output | NUM_BANKS | Per-bank memory power enables |
| wl_clamp | output | 1 | Word-line clamp |
| io_clamp | output | 1 | I/O clamp |
| core_clk_en | output | 1 | Core clock enable |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Clock-ready poll gave up |

## Verification
The in-module assertions check the ordering every cycle:
- the reset group rises together;
- the head switch only rises once the clock reports running;
- the regulator bypass only follows a head switch that was already on;
- the memory clamp is released before standby;
- banks rise one at a time and never fall;
- the clamps are removed only after all banks are on;
- the core runs last.

They also check that nothing moves after a timeout. The exact cycle spacing has to come from the bench's scenarios. That covers the microsecond gaps, the descending bank order, and the poll count at which the sequence gives up or still succeeds on the last attempt. The same holds for restart after a timeout and for a start pulse being ignored mid-sequence.

// File: rtl/pd_powerup_seq.sv
module pd_powerup_seq #(
  parameter int TICKS_PER_US = 4,
  parameter int NUM_BANKS    = 20,
  parameter int POLL_LIMIT   = 200
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 clk_off,
  output logic                 core_stop,
  output logic                 core_ares,
  output logic                 bus_ares_en,
  output logic                 xo_clk_en,
  output logic                 head_sw_on,
  output logic                 ldo_bypass,
  output logic                 qmc_clamp,
  output logic                 l2_stby_n,
  output logic                 slp_ret_n,
  output logic [NUM_BANKS-1:0] bank_pwr,
  output logic                 wl_clamp,
  output logic                 io_clamp,
  output logic                 core_clk_en,
  output logic                 done,
  output logic                 timeout_err
);

  localparam int TW = (TICKS_PER_US > 1) ? $clog2(TICKS_PER_US) : 1;
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam logic [TW-1:0] T_LAST = TW'(TICKS_PER_US - 1);
  localparam logic [PW-1:0] P_LAST = PW'(POLL_LIMIT - 1);
  localparam logic [BW-1:0] B_TOP  = BW'(NUM_BANKS - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_XO, S_POLL, S_HSW, S_QMC, S_STBY, S_BANK, S_BWAIT,
    S_IO, S_CARES, S_CCLK, S_CSTOP, S_FAIL
  } state_t;

  state_t          state;
  logic [TW-1:0]   timer;
  logic [PW-1:0]   polls;
  logic [BW-1:0]   idx;
  logic            tick;

  assign tick = (timer == T_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      timer       <= '0;
      polls       <= '0;
      idx         <= '0;
      core_stop   <= 1'b0;
      core_ares   <= 1'b0;
      bus_ares_en <= 1'b0;
      xo_clk_en   <= 1'b0;
      head_sw_on  <= 1'b0;
      ldo_bypass  <= 1'b0;
      qmc_clamp   <= 1'b1;
      l2_stby_n   <= 1'b0;
      slp_ret_n   <= 1'b0;
      bank_pwr    <= '0;
      wl_clamp    <= 1'b1;
      io_clamp    <= 1'b1;
      core_clk_en <= 1'b0;
      done        <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE, S_FAIL: begin
          if (start) begin
            core_stop   <= 1'b1;
            core_ares   <= 1'b1;
            bus_ares_en <= 1'b1;
            timeout_err <= 1'b0;
            state       <= S_XO;
          end
        end
        S_XO: begin
          xo_clk_en <= 1'b1;
          timer     <= '0;
          polls     <= '0;
          state     <= S_POLL;
        end
        S_POLL: begin
          if (tick) begin
            timer <= '0;
            if (!clk_off) begin
              head_sw_on <= 1'b1;
              state      <= S_HSW;
            end else if (polls == P_LAST) begin
              timeout_err <= 1'b1;
              state       <= S_FAIL;
            end else begin
              polls <= polls + PW'(1);
            end
          end else begin
            timer <= timer + TW'(1);
          end
        end
        S_HSW: begin
          if (tick) begin
            timer      <= '0;
            ldo_bypass <= 1'b1;
            state      <= S_QMC;
          end else begin
            timer <= timer + TW'(1);
          end
        end
        S_QMC: begin
          qmc_clamp <= 1'b0;
          state     <= S_STBY;
        end
        S_STBY: begin
          l2_stby_n <= 1'b1;
          slp_ret_n <= 1'b1;
          idx       <= B_TOP;
          state     <= S_BANK;
        end
        S_BANK: begin
          bank_pwr[idx] <= 1'b1;
          timer         <= '0;
          state         <= S_BWAIT;
        end
        S_BWAIT: begin
          if (tick) begin
            timer <= '0;
            if (idx == '0) begin
              wl_clamp <= 1'b0;
              state    <= S_IO;
            end else begin
              bank_pwr[idx - BW'(1)] <= 1'b1;
              idx                    <= idx - BW'(1);
            end
          end else begin
            timer <= timer + TW'(1);
          end
        end
        S_IO: begin
          io_clamp <= 1'b0;
          state    <= S_CARES;
        end
        S_CARES: begin
          core_ares <= 1'b0;
          state     <= S_CCLK;
        end
        S_CCLK: begin
          core_clk_en <= 1'b1;
          state       <= S_CSTOP;
        end
        S_CSTOP: begin
          core_stop <= 1'b0;
          done      <= 1'b1;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r2_reset_group: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_ares) |-> core_stop && bus_ares_en);

  a_r3_head_needs_clock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(head_sw_on) |-> xo_clk_en && !$past(clk_off));

  a_r4_hold_after_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_err && !start) |=> $stable({core_stop, core_ares, bus_ares_en, xo_clk_en,
      head_sw_on, ldo_bypass, qmc_clamp, bank_pwr, wl_clamp, io_clamp, core_clk_en}) && !done);

  a_r5_ldo_after_head: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ldo_bypass) |-> $past(head_sw_on));

  a_r6_clamp_before_standby: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(l2_stby_n) |-> !qmc_clamp && slp_ret_n);

  a_r7_one_bank_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_pwr & ~$past(bank_pwr)) && ((bank_pwr & $past(bank_pwr)) == $past(bank_pwr)));

  a_r8_wl_after_banks: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wl_clamp) |-> &bank_pwr);

  a_r8_io_after_wl: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(io_clamp) |-> !wl_clamp);

  a_r9_clock_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_clk_en) |-> !core_ares && !io_clamp);

  a_r9_run_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_stop) |-> core_clk_en && done);

endmodule

// File: tb/pd_powerup_seq_bench.sv
module pd_powerup_seq_bench;
  localparam int T  = 4;
  localparam int NB = 20;
  localparam int PL = 200;
  localparam int NEVER = 1000000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic clk_off = 1'b1;
  logic core_stop, core_ares, bus_ares_en, xo_clk_en, head_sw_on, ldo_bypass;
  logic qmc_clamp, l2_stby_n, slp_ret_n, wl_clamp, io_clamp, core_clk_en;
  logic done, timeout_err;
  logic [NB-1:0] bank_pwr;

  int checks = 0;
  int errors = 0;
  int wd = 0;

  int c_stop, c_ares, c_bus, c_xo, c_head, c_ldo, c_qmc, c_stby, c_slp;
  int c_wl, c_io, c_ares_off, c_clk, c_stop_off, c_done, c_to, c_to_clr, done_cnt;
  int c_bank [NB];

  always #2 clk = ~clk;

  pd_powerup_seq #(.TICKS_PER_US(T), .NUM_BANKS(NB), .POLL_LIMIT(PL)) u_pd_powerup_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .clk_off(clk_off),
    .core_stop(core_stop), .core_ares(core_ares), .bus_ares_en(bus_ares_en),
    .xo_clk_en(xo_clk_en), .head_sw_on(head_sw_on), .ldo_bypass(ldo_bypass),
    .qmc_clamp(qmc_clamp), .l2_stby_n(l2_stby_n), .slp_ret_n(slp_ret_n),
    .bank_pwr(bank_pwr), .wl_clamp(wl_clamp), .io_clamp(io_clamp),
    .core_clk_en(core_clk_en), .done(done), .timeout_err(timeout_err)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected below 100000", wd);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    start = 1'b0;
    clk_off = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // rec value = edge index after the start edge plus one
  task automatic run_seq(input int rel, input int ncyc, input int extra);
    c_stop = -1; c_ares = -1; c_bus = -1; c_xo = -1; c_head = -1; c_ldo = -1;
    c_qmc = -1; c_stby = -1; c_slp = -1; c_wl = -1; c_io = -1; c_ares_off = -1;
    c_clk = -1; c_stop_off = -1; c_done = -1; c_to = -1; c_to_clr = -1; done_cnt = 0;
    for (int b = 0; b < NB; b++) c_bank[b] = -1;
    clk_off = (rel <= 1) ? 1'b0 : 1'b1;
    start = 1'b1;
    for (int cyc = 1; cyc <= ncyc; cyc++) begin
      @(negedge clk);
      start = (cyc == extra);
      if (cyc == rel) clk_off = 1'b0;
      if (core_stop && c_stop < 0) c_stop = cyc;
      if (core_ares && c_ares < 0) c_ares = cyc;
      if (bus_ares_en && c_bus < 0) c_bus = cyc;
      if (xo_clk_en && c_xo < 0) c_xo = cyc;
      if (head_sw_on && c_head < 0) c_head = cyc;
      if (ldo_bypass && c_ldo < 0) c_ldo = cyc;
      if (!qmc_clamp && c_qmc < 0) c_qmc = cyc;
      if (l2_stby_n && c_stby < 0) c_stby = cyc;
      if (slp_ret_n && c_slp < 0) c_slp = cyc;
      for (int b = 0; b < NB; b++) if (bank_pwr[b] && c_bank[b] < 0) c_bank[b] = cyc;
      if (!wl_clamp && c_wl < 0) c_wl = cyc;
      if (!io_clamp && c_io < 0) c_io = cyc;
      if (!core_ares && c_ares >= 0 && c_ares_off < 0) c_ares_off = cyc;
      if (core_clk_en && c_clk < 0) c_clk = cyc;
      if (!core_stop && c_stop >= 0 && c_stop_off < 0) c_stop_off = cyc;
      if (done) begin done_cnt++; if (c_done < 0) c_done = cyc; end
      if (timeout_err && c_to < 0) c_to = cyc;
      if (!timeout_err && c_to_clr < 0) c_to_clr = cyc;
    end
    start = 1'b0;
  endtask

  function automatic int head_edge(input int rel);
    int k = 1;
    while (1 + k * T < rel) k++;
    return 1 + k * T;
  endfunction

  task automatic check_timeline(input int h, input string tag);
    int b0 = h + T + 4 + (NB - 1) * T;
    chk({tag, " R2 core_stop"}, c_stop, 1);
    chk({tag, " R2 core_ares"}, c_ares, 1);
    chk({tag, " R2 bus_ares_en"}, c_bus, 1);
    chk({tag, " R3 xo_clk_en"}, c_xo, 2);
    chk({tag, " R3 head_sw_on"}, c_head, h + 1);
    chk({tag, " R5 ldo_bypass"}, c_ldo, h + T + 1);
    chk({tag, " R6 qmc_clamp"}, c_qmc, h + T + 2);
    chk({tag, " R6 l2_stby_n"}, c_stby, h + T + 3);
    chk({tag, " R6 slp_ret_n"}, c_slp, h + T + 3);
    for (int b = NB - 1; b >= 0; b--)
      chk($sformatf("%s R7 bank %0d", tag, b), c_bank[b], h + T + 4 + (NB - 1 - b) * T);
    chk({tag, " R8 wl_clamp"}, c_wl, b0 + T);
    chk({tag, " R8 io_clamp"}, c_io, b0 + T + 1);
    chk({tag, " R9 core_ares release"}, c_ares_off, b0 + T + 2);
    chk({tag, " R9 core_clk_en"}, c_clk, b0 + T + 3);
    chk({tag, " R9 core_stop release"}, c_stop_off, b0 + T + 4);
    chk({tag, " R9 done cycle"}, c_done, b0 + T + 4);
    chk({tag, " R9 done count"}, done_cnt, 1);
    chk({tag, " R4 no timeout"}, c_to, -1);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 enables", int'({core_stop, core_ares, bus_ares_en, xo_clk_en, head_sw_on,
        ldo_bypass, l2_stby_n, slp_ret_n, core_clk_en}), 0);
    chk("R1 banks", int'(bank_pwr), 0);
    chk("R1 clamps", int'({qmc_clamp, wl_clamp, io_clamp}), 7);
    chk("R1 done", int'(done), 0);
    chk("R1 timeout_err", int'(timeout_err), 0);
  endtask

  task automatic t_clock_ready_at_once();
    do_reset();
    run_seq(1, 120, -1);
    check_timeline(head_edge(1), "fast");
  endtask

  task automatic t_clock_ready_after_retries();
    do_reset();
    run_seq(10, 130, -1);
    check_timeline(head_edge(10), "retry");
  endtask

  task automatic t_last_poll_succeeds();
    do_reset();
    run_seq(PL * T, PL * T + 110, -1);
    check_timeline(head_edge(PL * T), "lastpoll");
  endtask

  task automatic t_timeout_then_restart();
    do_reset();
    run_seq(NEVER, PL * T + 20, -1);
    chk("R4 timeout cycle", c_to, 2 + PL * T);
    chk("R4 head stays off", c_head, -1);
    chk("R4 no done", done_cnt, 0);
    chk("R4 held outputs", int'({core_stop, core_ares, bus_ares_en, xo_clk_en,
        head_sw_on, ldo_bypass, qmc_clamp, wl_clamp, io_clamp}), 9'b111100111);
    chk("R4 banks off", int'(bank_pwr), 0);
    chk("R4 error held", int'(timeout_err), 1);
    run_seq(1, 120, -1);
    chk("R2 error cleared by restart", c_to_clr, 1);
    chk("R4 restart head", c_head, head_edge(1) + 1);
    chk("R4 restart done", c_done, head_edge(1) + 8 + (NB + 1) * T);
    chk("R4 restart done count", done_cnt, 1);
  endtask

  task automatic t_start_while_busy();
    do_reset();
    run_seq(1, 130, 30);
    check_timeline(head_edge(1), "busy_start R10");
  endtask

  initial begin
    t_reset_state();
    t_clock_ready_at_once();
    t_clock_ready_after_retries();
    t_last_poll_succeeds();
    t_timeout_then_restart();
    t_start_while_busy();
    summary();
    $finish;
  end
endmodule